// File: doc/BRIEF.md
# Double-Buffered 16-bit PWM Generator

This block drives one pulse-width-modulated output from a reference tick enable. The tick enable runs at 7.5 MHz in the intended system, so the output frequency is 7.5 MHz divided by the programmed period. A byte-wide register port gives software four registers. From byte address 0 upward they are: period low, period high, duty low and duty high. Software can write each register and read it back.

Every write lands in a shadow copy first. A write to the duty high byte, and no other write, arms a commit. The armed commit copies the shadow period and duty into the active registers on the tick that ends the current period. A new setting therefore starts at the beginning of a cycle, and no pulse is ever cut short or lengthened.

A 16-bit counter advances on each tick and wraps after period minus one. The output is high while the counter is below the active duty. As a result, a zero duty holds the output low, and a duty at or above the period holds it high.

Top module: `dbuf_pwm`

## Requirements
- R1: Byte addresses 0, 1, 2 and 3 select period bits 7:0, period bits 15:8, duty bits 7:0 and duty bits 15:8. `rd_data` shows, without delay, the last value written to the register selected by `addr`.
- R2: The counter advances only on cycles with `tick_en` high and wraps to zero after reaching active period minus one. The output repeats every `period` ticks.
- R3: For 0 < duty < period, the output is high for exactly `duty` ticks of every period, starting at counter zero.
- R4: With an active duty of zero, the output stays low on every cycle.
- R5: With an active duty equal to or greater than the active period, the output stays high on every cycle.
- R6: Writes to addresses 0, 1 and 2 change only the shadow registers. The running output keeps its period and duty.
- R7: A write to address 3 arms a commit. At the next tick that wraps the counter, the shadow period and duty become active, and the new waveform starts from counter zero.
- R8: A committed period below 2 is used as 2.
- R9: After reset, all four registers read zero, the active period is 2, the active duty is zero and the output is low.
- R10: The active period and duty change only on a wrapping tick, so the current cycle always completes with its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Reference tick enable; one counter step per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register byte address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read-back data for `addr` |
| pwm_out | output | 1 | PWM output |

## Verification
On every cycle, the assertions check the following. The counter stays below the active period, and the active period never drops below 2. The active settings move only on a wrapping tick. A write to address 3 always leaves a commit armed. Zero duty means a low output, and a duty at or above the period means a high output. Only the directed scenarios can show the actual waveform: the count of high ticks per period, the spacing between rising edges under a gated tick, and the exact cycle at which a committed setting first appears after the old cycle ends.

// File: rtl/dbuf_pwm.sv
module dbuf_pwm #(
  parameter int DW         = 8,
  parameter int MIN_PERIOD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          pwm_out
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] PMIN = CW'(MIN_PERIOD);

  logic [CW-1:0] sh_per, sh_duty, act_per, act_duty, cnt;
  logic          pend;

  wire           wrap    = tick_en && (cnt == act_per - 1'b1);
  wire           hi_wr   = wr_en && (addr == 2'd3);
  wire [CW-1:0]  per_fix = (sh_per < PMIN) ? PMIN : sh_per;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_per   <= '0;
      sh_duty  <= '0;
      act_per  <= PMIN;
      act_duty <= '0;
      cnt      <= '0;
      pend     <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          2'd0: sh_per[DW-1:0]   <= wr_data;
          2'd1: sh_per[CW-1:DW]  <= wr_data;
          2'd2: sh_duty[DW-1:0]  <= wr_data;
          2'd3: sh_duty[CW-1:DW] <= wr_data;
          default: ;
        endcase
      end
      if (tick_en) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap && pend) begin
        act_per  <= per_fix;
        act_duty <= sh_duty;
        pend     <= 1'b0;
      end
      if (hi_wr) pend <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = sh_per[DW-1:0];
      2'd1:    rd_data = sh_per[CW-1:DW];
      2'd2:    rd_data = sh_duty[DW-1:0];
      default: rd_data = sh_duty[CW-1:DW];
    endcase
  end

  assign pwm_out = (cnt < act_duty);

  assert_min_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_per >= PMIN);

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act_per);

  assert_hold_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_per) && $stable(act_duty)));

  assert_arm_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> pend);

  assert_shadow_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 2'd3 && !pend) |=> ($stable(act_per) && $stable(act_duty)));

  assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty == '0) |-> !pwm_out);

  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty >= act_per) |-> pwm_out);
endmodule

// File: tb/tb_dbuf_pwm.sv
module tb_dbuf_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  dbuf_pwm dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic config_pwm(input int per, input int duty);
    wr(2'd0, per[7:0]);
    wr(2'd1, per[15:8]);
    wr(2'd2, duty[7:0]);
    wr(2'd3, duty[15:8]);
    repeat (700) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic rise_gap(input bit toggle, output int gap);
    logic prev;
    int k;
    gap = -1;
    @(negedge clk);
    prev = pwm_out;
    k = 0;
    for (int i = 0; i < 2000 && gap < 0; i++) begin
      @(negedge clk);
      if (toggle) tick_en = ~tick_en;
      if (k > 0) k++;
      if (pwm_out && !prev) begin
        if (k > 0) gap = k - 1;
        else k = 1;
      end
      prev = pwm_out;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    int h;
    count_high(8, h);
    check("R9 output low after reset", h, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R9 register reads zero", d, 0);
    end
  endtask

  task automatic t_readback_basic();
    logic [7:0] d;
    int h, g;
    wr(2'd0, 8'h0C); wr(2'd1, 8'hA5); wr(2'd2, 8'h05);
    rd(2'd0, d); check("R1 period low readback", d, 8'h0C);
    rd(2'd1, d); check("R1 period high readback", d, 8'hA5);
    rd(2'd2, d); check("R1 duty low readback", d, 8'h05);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, d); check("R1 duty high readback", d, 8'h00);
    rd(2'd1, d); check("R1 period high rewrite", d, 8'h00);
    repeat (40) @(negedge clk);
    count_high(48, h);
    check("R3 high ticks in 4 periods of 12/5", h, 20);
    rise_gap(1'b0, g);
    check("R2 period 12 spacing", g, 12);
  endtask

  task automatic t_shadow_only();
    int h, g;
    wr(2'd0, 8'd4);
    wr(2'd2, 8'd1);
    repeat (40) @(negedge clk);
    count_high(48, h);
    check("R6 duty unchanged without high-byte write", h, 20);
    rise_gap(1'b0, g);
    check("R6 period unchanged without high-byte write", g, 12);
  endtask

  task automatic t_commit_boundary();
    logic prev;
    int exp;
    int mism;
    @(negedge clk);
    prev = pwm_out;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    tick_en = 1'b0;
    wr(2'd0, 8'd6); wr(2'd1, 8'd0); wr(2'd2, 8'd2); wr(2'd3, 8'd0);
    tick_en = 1'b1;
    mism = 0;
    for (int i = 0; i < 18; i++) begin
      exp = (i < 5) ? 1 : (i < 12) ? 0 : (i < 14) ? 1 : 0;
      if (pwm_out !== exp[0]) begin
        mism++;
        $display("FAIL R7/R10 sample %0d actual=%0b expected=%0d", i, pwm_out, exp);
      end
      @(negedge clk);
    end
    total++;
    if (mism != 0) bad++;
  endtask

  task automatic t_duty_zero();
    int h;
    config_pwm(6, 0);
    count_high(30, h);
    check("R4 zero duty stays low", h, 0);
  endtask

  task automatic t_duty_full();
    int h;
    config_pwm(6, 6);
    count_high(30, h);
    check("R5 duty equal to period stays high", h, 30);
    config_pwm(6, 16'h0100);
    count_high(30, h);
    check("R5 duty above period stays high", h, 30);
  endtask

  task automatic t_min_period();
    int h, g;
    config_pwm(0, 1);
    rise_gap(1'b0, g);
    check("R8 period 0 runs as 2", g, 2);
    count_high(20, h);
    check("R8 period 0 half high", h, 10);
    config_pwm(1, 1);
    rise_gap(1'b0, g);
    check("R8 period 1 runs as 2", g, 2);
  endtask

  task automatic t_tick_gating();
    int g;
    config_pwm(5, 2);
    rise_gap(1'b1, g);
    check("R2 half-rate ticks double spacing", g, 10);
    tick_en = 1'b1;
  endtask

  task automatic t_wide_period();
    int h, g;
    config_pwm(16'h0104, 16'h0082);
    rise_gap(1'b0, g);
    check("R2 period 260 spacing", g, 260);
    count_high(520, h);
    check("R3 duty 130 of 260", h, 260);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    tick_en = 1'b1;
    t_readback_basic();
    t_shadow_only();
    t_commit_boundary();
    t_duty_zero();
    t_duty_full();
    t_min_period();
    t_tick_gating();
    t_wide_period();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule